// File: doc/BRIEF.md
# Sign-Bit Controlled Adder-Subtractor

This unit combines two operand words held in a sign-in-top-bit format. The second operand carries its own operation code: its top bit picks subtraction when set and addition when clear. Its lower bits give the magnitude. The first operand takes part as a plain unsigned word of the full operand width.

An adder path and a subtractor path both compute in parallel. A select driven by the second operand's top bit chooses one of them. The chosen value is registered together with a valid flag.

The result is one bit wider than an operand. A sum never overflows. A difference that goes below zero wraps modulo 2^(OP_W+1), so the caller can read it as a two's complement value. The block does not normalise the result back into sign-magnitude form.

Top module: `sbas_addsub`

## Requirements
- R1: While rst_ni is low, result_o is 0 and valid_o is 0, with the clear taking effect without waiting for a clock edge.
- R2: When valid_i is high and b_i[5] is 0, the edge that samples the operands loads result_o with the unsigned sum a_i + b_i[4:0], all 7 bits kept (maximum 94).
- R3: When valid_i is high and b_i[5] is 1, the edge that samples the operands loads result_o with (a_i - b_i[4:0]) mod 128.
- R4: a_i[5] is a value bit worth 32 in both operations and never changes the operation.
- R5: A second operand of 6'b100000 (a negative zero) makes result_o equal a_i.
- R6: valid_o at each rising edge takes the value valid_i had just before that edge.
- R7: When valid_i is low at an edge, result_o keeps its value, whatever a_i and b_i carry.
- R8: Back-to-back valid cycles whose b_i[5] differ produce the add result and then the subtract result on consecutive cycles, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on a_i and b_i are to be used |
| a_i | input | 6 | First operand, treated as unsigned |
| b_i | input | 6 | Second operand; bit 5 selects subtract, bits 4:0 are the magnitude |
| result_o | output | 7 | Registered sum, or difference modulo 128 |
| valid_o | output | 1 | result_o was loaded at the last edge |

## Verification
Two events can land on the same edge: the select changing paths and the register loading a new value. This happens when b_i[5] flips between two valid cycles that follow each other. It is provoked by the exhaustive sweep, whose inner loop crosses the sign boundary. A directed add-then-subtract pair adds a cycle-exact check after each edge. Reset and a live valid_i are also made to coincide. That case is judged by result_o and valid_o reading zero at once, while the operands still request a load.

// File: rtl/sbas_pkg.sv
package sbas_pkg;
  localparam int unsigned OP_W_DEF = 6;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/sbas_split.sv
module sbas_split
  import sbas_pkg::*;
#(
  parameter int unsigned OP_W  = OP_W_DEF,
  localparam int unsigned MAG_W = OP_W - 1
) (
  input  logic [OP_W-1:0]  b_i,
  output logic [MAG_W-1:0] mag_o,
  output op_e              op_o
);
  assign mag_o = b_i[MAG_W-1:0];
  assign op_o  = op_e'(b_i[OP_W-1]);
endmodule

// File: rtl/sbas_path.sv
module sbas_path #(
  parameter int unsigned OP_W  = 6,
  parameter bit          SUB   = 1'b0,
  localparam int unsigned MAG_W = OP_W - 1,
  localparam int unsigned RES_W = OP_W + 1
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [RES_W-1:0] res_o
);
  logic [RES_W-1:0] a_ext, m_ext;

  assign a_ext = RES_W'(a_i);
  assign m_ext = RES_W'(mag_i);

  generate
    if (SUB) begin : g_sub
      assign res_o = a_ext - m_ext;
    end else begin : g_add
      assign res_o = a_ext + m_ext;
    end
  endgenerate
endmodule

// File: rtl/sbas_addsub.sv
module sbas_addsub
  import sbas_pkg::*;
#(
  parameter int unsigned OP_W  = OP_W_DEF,
  localparam int unsigned MAG_W = OP_W - 1,
  localparam int unsigned RES_W = OP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  logic [MAG_W-1:0] mag;
  op_e              op;
  logic [RES_W-1:0] sum, diff, sel;

  sbas_split #(.OP_W(OP_W)) u_split (
    .b_i  (b_i),
    .mag_o(mag),
    .op_o (op)
  );

  sbas_path #(.OP_W(OP_W), .SUB(1'b0)) u_add (
    .a_i  (a_i),
    .mag_i(mag),
    .res_o(sum)
  );

  sbas_path #(.OP_W(OP_W), .SUB(1'b1)) u_sub (
    .a_i  (a_i),
    .mag_i(mag),
    .res_o(diff)
  );

  assign sel = (op == OP_SUB) ? diff : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= sel;
    end
  end
endmodule

// File: rtl/sbas_chk.sv
module sbas_chk #(
  parameter int unsigned OP_W  = 6,
  localparam int unsigned MAG_W = OP_W - 1,
  localparam int unsigned RES_W = OP_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OP_W-1:0]  a_i,
  input logic [OP_W-1:0]  b_i,
  input logic [RES_W-1:0] result_o,
  input logic             valid_o
);
  logic [RES_W-1:0] ref_add, ref_sub;
  assign ref_add = RES_W'(a_i) + RES_W'(b_i[MAG_W-1:0]);
  assign ref_sub = RES_W'(a_i) - RES_W'(b_i[MAG_W-1:0]);

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (result_o == '0 && !valid_o); // R1
  end

  AST_ADD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !b_i[OP_W-1] |=> result_o == $past(ref_add)); // R2

  AST_SUB_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && b_i[OP_W-1] |=> result_o == $past(ref_sub)); // R3

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6

  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R7
endmodule

bind sbas_addsub sbas_chk #(.OP_W(OP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .result_o(result_o),
  .valid_o (valid_o)
);

// File: tb/sim_sbas_addsub.sv
module sim_sbas_addsub;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [5:0] a_i = '0, b_i = '0;
  logic [6:0] result_o;
  logic       valid_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sbas_addsub u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .valid_o(valid_o)
  );

  // {a, b, expected result}
  localparam logic [18:0] VEC [12] = '{
    {6'd0,  6'd0,  7'd0},
    {6'd10, 6'd5,  7'd15},
    {6'd63, 6'd31, 7'd94},
    {6'd40, 6'd20, 7'd60},
    {6'd20, 6'd37, 7'd15},
    {6'd5,  6'd42, 7'd123},
    {6'd0,  6'd63, 7'd97},
    {6'd63, 6'd63, 7'd32},
    {6'd17, 6'd32, 7'd17},
    {6'd31, 6'd1,  7'd32},
    {6'd1,  6'd33, 7'd0},
    {6'd32, 6'd63, 7'd1}
  };

  function automatic logic [6:0] ref_res(input int a, input int b);
    int e;
    e = (b >= 32) ? a - (b - 32) : a + b;
    return 7'(e & 127);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] a, input logic [5:0] b, input logic v);
    @(negedge clk);
    a_i = a; b_i = b; valid_i = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", result_o, 0);
    chk("R1 reset valid", valid_o, 0);
    rst_ni = 1'b1;

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][18:13], VEC[i][12:7], 1'b1);
      chk(VEC[i][12] ? "R3 table" : "R2 table", result_o, VEC[i][6:0]);
      chk("R6 valid", valid_o, 1);
    end

    // exhaustive sweep, consecutive valid cycles (R2 R3 R4)
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        apply(6'(a), 6'(b), 1'b1);
        chk(b >= 32 ? "R3 sweep" : "R2 sweep", result_o, ref_res(a, b));
      end
    end

    // R5 negative zero
    apply(6'd45, 6'd32, 1'b1);
    chk("R5 neg zero", result_o, 45);

    // R7 hold with changed operands, R6 valid drop
    apply(6'd12, 6'd3, 1'b1);
    chk("R2 before hold", result_o, 15);
    apply(6'd50, 6'd60, 1'b0);
    chk("R7 hold", result_o, 15);
    chk("R6 valid low", valid_o, 0);
    apply(6'd7, 6'd40, 1'b0);
    chk("R7 hold again", result_o, 15);

    // R8 add then subtract, back to back
    @(negedge clk);
    a_i = 6'd9; b_i = 6'd4; valid_i = 1'b1;
    @(negedge clk);
    chk("R8 add cycle", result_o, 13);
    a_i = 6'd9; b_i = 6'd36;
    @(negedge clk);
    chk("R8 sub cycle", result_o, 5);
    chk("R8 valid", valid_o, 1);

    // R1 reset while valid_i high, clears without an edge
    a_i = 6'd30; b_i = 6'd10;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async result", result_o, 0);
    chk("R1 async valid", valid_o, 0);
    @(negedge clk);
    chk("R1 held in reset", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 after reset", result_o, 40);

    finish_run();
  end
endmodule